// File: doc/BRIEF.md
# Addressed SPI Peripheral with Shared Reply Line

This block is the device side of an SPI link in mode 0 (clock idles low, data captured on the rising clock edge and changed on the falling edge). Several copies hang off one controller. The controller picks a copy by driving a 2-bit device code together with a bus-active flag, and each copy holds its own fixed code as a parameter. Only the copy whose code matches takes part in a transfer. It captures the controller's command word from COPI, MSB first. At the same time it sends its own reply word, which is longer, back on CIPO. While a copy is not addressed it releases CIPO to high impedance, so up to four copies can drive a single return line.

The block runs on the system clock. The controller's SCK is treated as a slow signal in the same clock domain, and edges are found by comparing SCK with its value one clock earlier. The controller must hold SCK low when it selects a device. It must leave at least one system clock between the select and the first rising edge of SCK. Each SCK level must last at least two system clocks.

The control FSM has three states:
- `ST_IDLE`: not addressed. The reply register follows `reply_word` on every clock and the bit counter is held at 0.
- `ST_RECV`: addressed, capturing command bits.
- `ST_TAIL`: the command word is complete and the rest of the reply is being shifted out.

The transitions are:
- `ST_IDLE`→`ST_RECV` on select.
- `ST_RECV`→`ST_TAIL` on the rising edge that captures the last command bit.
- `ST_RECV`/`ST_TAIL`→`ST_IDLE` on deselect.

Top module: `spi_per_node`

## Requirements
- R1: The block is addressed only while `cs_act` is 1 and `cs_code` equals the `ADDR` parameter. SCK activity while it is not addressed produces no `rx_valid` pulse and leaves `rx_word` unchanged.
- R2: While the block is not addressed, `cipo` is high impedance. While it is addressed, `cipo` is driven with the current reply bit.
- R3: COPI is sampled on each rising SCK edge, MSB first. The first `RX_W` bits (default 8) of a transaction form the received word, with bit `RX_W-1` being the first bit captured.
- R4: The reply word is taken from `reply_word` when the transaction starts. Its bit `TX_W-1` (default 16) is on `cipo` before the first rising edge. The next lower bit follows after each falling edge, and 0 is sent once all `TX_W` bits have gone.
- R5: `rx_valid` is high for exactly one system clock. That clock is the one after the clock edge that registers the rising SCK edge carrying bit `RX_W`. `rx_word` changes only together with that pulse and is held until the next one.
- R6: COPI bits after the `RX_W`-th bit of a transaction are ignored: there is no second pulse and `rx_word` is unchanged.
- R7: Deselecting the block clears the bit counter. A transaction aborted before `RX_W` bits gives no pulse, and the next transaction starts again at bit 0.
- R8: After reset `rx_valid` is 0, `rx_word` is 0, the bit counter is 0 and the FSM is in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_act | input | 1 | A device code is being driven on `cs_code` |
| cs_code | input | CS_W | Encoded device code selected by the controller |
| sck | input | 1 | Serial clock from the controller (mode 0) |
| copi | input | 1 | Serial data from the controller |
| cipo | output | 1 | Serial reply, high impedance when not addressed |
| reply_word | input | TX_W | Reply word taken at transaction start |
| rx_word | output | RX_W | Last complete received word |
| rx_valid | output | 1 | One-clock strobe marking a new `rx_word` |

## Verification
Four copies share one pulled-up return line, and transfers rotate through every address. A copy that ignores the device code would either assert a stray strobe or fight on the line, and one that does not release the line would pull it away from the pulled-up level between transfers. A transfer is aborted after three bits and then repeated in full. A counter that survived the deselect would produce a shifted word or an early strobe. The tail of each transfer carries random COPI bits, so a receiver that keeps shifting past the word length would corrupt the held word or pulse a second time. Every reply bit is compared just before its rising edge, which exposes a late load, an off-by-one-edge shift or a wrong bit order.

// File: rtl/spi_per_pkg.sv
package spi_per_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_TAIL = 2'd2
    } per_state_t;
endpackage

// File: rtl/spi_per_edge.sv
module spi_per_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic sck_rise,
    output logic sck_fall
);
    logic sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    assign sck_rise = sck & ~sck_q;
    assign sck_fall = ~sck & sck_q;
endmodule

// File: rtl/spi_per_rx.sv
module spi_per_rx #(
    parameter int RX_W  = 8,
    parameter int CNT_W = $clog2(RX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [CNT_W-1:0] cnt,
    output logic             last_bit,
    output logic [RX_W-1:0]  word_o,
    output logic             valid_o
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(RX_W - 1);

    logic [RX_W-1:0] sr;

    assign last_bit = en && (cnt == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr  <= '0;
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            sr  <= {sr[RX_W-2:0], din};
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= last_bit;
            if (last_bit) word_o <= {sr[RX_W-2:0], din};
        end
    end
endmodule

// File: rtl/spi_per_tx.sv
module spi_per_tx #(
    parameter int TX_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            shift,
    input  logic [TX_W-1:0] reply,
    output logic            dout
);
    logic [TX_W-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sr <= '0;
        else if (load)  sr <= reply;
        else if (shift) sr <= {sr[TX_W-2:0], 1'b0};
    end

    assign dout = sr[TX_W-1];
endmodule

// File: rtl/spi_per_node.sv
module spi_per_node
    import spi_per_pkg::*;
#(
    parameter int CS_W = 2,
    parameter int ADDR = 0,
    parameter int RX_W = 8,
    parameter int TX_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_act,
    input  logic [CS_W-1:0] cs_code,
    input  logic            sck,
    input  logic            copi,
    output logic            cipo,
    input  logic [TX_W-1:0] reply_word,
    output logic [RX_W-1:0] rx_word,
    output logic            rx_valid
);
    localparam int CNT_W = $clog2(RX_W + 1);
    localparam logic [CS_W-1:0] MY_CODE = CS_W'(ADDR);

    per_state_t       state, state_nx;
    logic             sel;
    logic             sck_rise, sck_fall;
    logic             rx_en, tx_load, tx_shift;
    logic             last_bit, tx_bit, drive_en;
    logic [CNT_W-1:0] bit_cnt;

    assign sel = cs_act && (cs_code == MY_CODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        rx_en    = 1'b0;
        tx_load  = 1'b0;
        tx_shift = 1'b0;
        unique case (state)
            ST_IDLE: begin
                tx_load = 1'b1;
                if (sel) state_nx = ST_RECV;
            end
            ST_RECV: begin
                rx_en    = sel && sck_rise;
                tx_shift = sel && sck_fall;
                if (!sel)          state_nx = ST_IDLE;
                else if (last_bit) state_nx = ST_TAIL;
            end
            ST_TAIL: begin
                tx_shift = sel && sck_fall;
                if (!sel) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    spi_per_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall)
    );

    spi_per_rx #(.RX_W(RX_W), .CNT_W(CNT_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!sel),
        .en       (rx_en),
        .din      (copi),
        .cnt      (bit_cnt),
        .last_bit (last_bit),
        .word_o   (rx_word),
        .valid_o  (rx_valid)
    );

    spi_per_tx #(.TX_W(TX_W)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tx_load),
        .shift (tx_shift),
        .reply (reply_word),
        .dout  (tx_bit)
    );

    assign drive_en = sel;
    assign cipo     = drive_en ? tx_bit : 1'bz;
endmodule

module spi_per_node_chk
    import spi_per_pkg::*;
#(
    parameter int CS_W  = 2,
    parameter int ADDR  = 0,
    parameter int RX_W  = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_act,
    input logic [CS_W-1:0]  cs_code,
    input per_state_t       state,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             drive_en,
    input logic [RX_W-1:0]  rx_word,
    input logic             rx_valid
);
    logic addressed;
    assign addressed = cs_act && (cs_code == CS_W'(ADDR));

    // R2
    drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addressed |-> !drive_en);

    // R1
    idle_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addressed |=> state == ST_IDLE);

    // R7
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addressed |=> bit_cnt == '0);

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R5
    word_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_word) |-> rx_valid);

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(RX_W));

    // R3
    tail_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL) |-> (bit_cnt == CNT_W'(RX_W)));
endmodule

bind spi_per_node spi_per_node_chk #(
    .CS_W  (CS_W),
    .ADDR  (ADDR),
    .RX_W  (RX_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act   (cs_act),
    .cs_code  (cs_code),
    .state    (state),
    .bit_cnt  (bit_cnt),
    .drive_en (drive_en),
    .rx_word  (rx_word),
    .rx_valid (rx_valid)
);

// File: tb/spi_per_node_tb.sv
module spi_per_node_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RX_W = 8;
    localparam int TX_W = 16;
    localparam int HALF = 3;
    localparam int NDEV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_act = 1'b0;
    logic [1:0] cs_code = '0;
    logic sck = 1'b0;
    logic copi = 1'b0;
    logic [NDEV-1:0][TX_W-1:0] reply_w = '0;
    logic [NDEV-1:0][RX_W-1:0] rx_word;
    logic [NDEV-1:0] rx_valid;
    wire cipo_bus;

    pullup (cipo_bus);

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [RX_W+1:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar g = 0; g < NDEV; g++) begin : g_node
        spi_per_node #(.CS_W(2), .ADDR(g), .RX_W(RX_W), .TX_W(TX_W)) u_dut (
            .clk        (clk),
            .rst_n      (rst_n),
            .cs_act     (cs_act),
            .cs_code    (cs_code),
            .sck        (sck),
            .copi       (copi),
            .cipo       (cipo_bus),
            .reply_word (reply_w[g]),
            .rx_word    (rx_word[g]),
            .rx_valid   (rx_valid[g])
        );
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: one transaction of nbits SCK periods to device a
    task automatic xfer(input int a, input logic [RX_W-1:0] d,
                        input logic [TX_W-1:0] rep, input int nbits);
        reply_w[a] = rep;
        cs_code    = 2'(a);
        cs_act     = 1'b1;
        if (nbits >= RX_W) exp_q.push_back({2'(a), d});
        clks(2);
        for (int i = 0; i < nbits; i++) begin
            copi = (i < RX_W) ? d[RX_W-1-i] : 1'($urandom);
            clks(HALF);
            // R4: reply bit on the line before the rising edge
            check("R4 reply bit", 32'(cipo_bus), 32'(rep[TX_W-1-i]));
            sck = 1'b1;
            clks(HALF);
            sck = 1'b0;
        end
        clks(HALF);
        cs_act = 1'b0;
        clks(1);
        // R2: nobody addressed, line released to the pull-up
        check("R2 line released", 32'(cipo_bus), 32'd1);
        clks(2);
    endtask

    // Monitor: scoreboard for received words
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NDEV; i++) begin
                if (rx_valid[i]) begin
                    if (exp_q.size() == 0) begin
                        check("R1/R6/R7 unexpected strobe", 32'(i), 32'hFFFF);
                    end else begin
                        logic [RX_W+1:0] e;
                        e = exp_q.pop_front();
                        check("R1 strobing device", 32'(i), 32'(e[RX_W+1:RX_W]));
                        check("R3 received word", 32'(rx_word[i]), 32'(e[RX_W-1:0]));
                    end
                end
            end
        end
    end

    // Monitor: strobe width
    logic [NDEV-1:0] v_d = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NDEV; i++)
                if (v_d[i]) check("R5 one-clock strobe", 32'(rx_valid[i]), 32'd0);
            v_d = rx_valid;
        end
    end

    initial begin
        clks(3);
        rst_n = 1'b1;
        clks(1);
        // R8: reset state
        check("R8 rx_valid after reset", 32'(rx_valid), 32'd0);
        check("R8 rx_word after reset", 32'(rx_word), 32'd0);
        check("R2 line released after reset", 32'(cipo_bus), 32'd1);

        // R2: selected device with all-zero reply pulls the line low
        reply_w[2] = '0;
        cs_code = 2'd2;
        cs_act  = 1'b1;
        clks(2);
        check("R2 addressed device drives", 32'(cipo_bus), 32'd0);
        cs_act = 1'b0;
        clks(2);

        // R3 R4: basic transfers to every address
        xfer(0, 8'hA5, 16'hC3E1, TX_W);
        xfer(1, 8'h3C, 16'h8001, TX_W);
        xfer(2, 8'hFF, 16'hFFFF, TX_W);
        xfer(3, 8'h00, 16'h5AA5, TX_W);

        // R7: aborted transfer then a full one to the same device
        xfer(1, 8'hE7, 16'h1234, 3);
        check("R7 no strobe after abort", 32'(exp_q.size()), 32'd0);
        xfer(1, 8'h81, 16'hBEEF, TX_W);

        // R6: word held after the tail bits
        check("R6 word held after tail", 32'(rx_word[1]), 32'h81);

        // R1: other devices did not change their words
        check("R1 device 0 word unchanged", 32'(rx_word[0]), 32'hA5);
        check("R1 device 3 word unchanged", 32'(rx_word[3]), 32'h00);

        // Random traffic
        for (int k = 0; k < 12; k++) begin
            xfer($urandom_range(0, 3), 8'($urandom), 16'($urandom), TX_W);
        end
        clks(4);
        check("R5 all words delivered", 32'(exp_q.size()), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule